// File: doc/BRIEF.md
# Reduced-Precision Floating-Point Shortcut Detector

This block sits ahead of a shared single-precision floating-point unit. Each cycle it may take one operation: add, subtract, multiply or divide, together with two operands and the number of significand bits the running thread actually needs. It decides whether the answer can be produced without the arithmetic unit. When it can, it returns the answer one cycle later and raises a hit flag, and the core skips dispatch to the shared unit. When it cannot, it reports a miss and the core sends the operation onward.

Two groups of shortcuts are recognised. The first group covers classic identities: a zero addend, or a zero or signed-unit factor. The second group relies on the programmable width. An addend whose exponent lies too far below the other's would be shifted completely out of a narrowed significand. A factor whose kept significand bits are all zero is a signed power of two. In these cases the other operand's full 23-bit fraction passes straight through, while the exponent and sign are still computed. Any case that might need overflow, underflow, NaN, infinity or subnormal handling is left to the full unit.

Top module: `tz_top`

## Requirements
- R1: After reset, and until the first accepted operation, out_valid, out_hit and out_result are all zero.
- R2: out_valid is high in the cycle after in_valid was high, and only then. A cycle with in_valid low gives out_hit = 0 and out_result = 0 in the next cycle.
- R3: Opcode in_op is 0 for add, 1 for subtract, 2 for multiply and 3 for divide (a op b). For add or subtract with b = ±0, the result is a. Otherwise, if a = ±0, add returns b and subtract returns b with bit 31 inverted. Both cases are hits.
- R4: For add or subtract with nonzero operands, when |exp(a) − exp(b)| exceeds the effective width plus one, the result is a hit. The value is the operand with the larger exponent at full precision, with bit 31 inverted when that operand is the subtrahend b. A gap equal to width plus one is a miss.
- R5: Multiply with either operand ±0 is a hit returning a zero whose sign is sign(a) XOR sign(b).
- R6: Multiply hits when the top w fraction bits (bits 22 down to 23−w) of a are zero, giving b's full fraction. Otherwise it hits when those bits of b are zero, giving a's full fraction. The exponent is exp(a)+exp(b)−127 and the sign is the XOR of the signs.
- R7: Divide with divisor ±0 is a miss. Divide with dividend ±0 is a hit returning a signed zero. Divide with a divisor whose full 23-bit fraction is zero is a hit returning a's fraction, exponent exp(a)−exp(b)+127, and the XOR of the signs. The width plays no part in this test.
- R8: A multiply or divide shortcut whose computed exponent falls outside 1..254 is a miss.
- R9: Any operand with exponent field 255 (NaN or infinity), or with exponent field 0 and a nonzero fraction (subnormal), forces a miss.
- R10: The effective width w is in_width clamped to 1..23: a value of 0 acts as 1, and any value above 23 acts as 23.
- R11: On a miss, out_hit is 0 and out_result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 divide |
| in_a | input | 32 | First operand (minuend, dividend) |
| in_b | input | 32 | Second operand (subtrahend, divisor) |
| in_width | input | 5 | Significand width in force for the thread |
| out_valid | output | 1 | Decision for the operation of the previous cycle |
| out_hit | output | 1 | Shortcut taken, skip the shared unit |
| out_result | output | 32 | Shortcut result, zero on a miss |

## Verification
Every decision passes through exactly one register, so each output is due in the cycle right after its operation is offered. The bench drives inputs on the falling edge. It computes the expected triple from the requirements at that moment and compares it with the outputs at the next falling edge, which is one rising edge later. Boundary gaps of width plus one and width plus two, width clamping, exponent range limits and idle cycles are placed directly into that one-cycle stream, and checks are spread between them.

// File: rtl/tz_pkg.sv
package tz_pkg;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int FP_W  = EXP_W + MAN_W + 1;
    localparam int WID_W = $clog2(MAN_W + 1);

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } tz_op_e;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic [FP_W-1:0] res;
    } tz_state_t;
endpackage

// File: rtl/tz_classify.sv
module tz_classify #(
    parameter int EXP_W = tz_pkg::EXP_W,
    parameter int MAN_W = tz_pkg::MAN_W,
    localparam int FP_W = EXP_W + MAN_W + 1
) (
    input  logic [FP_W-1:0]  val_i,
    output logic             sign_o,
    output logic [EXP_W-1:0] exp_o,
    output logic [MAN_W-1:0] man_o,
    output logic             is_zero_o,
    output logic             is_special_o
);
    always_comb begin
        sign_o       = val_i[FP_W-1];
        exp_o        = val_i[FP_W-2 -: EXP_W];
        man_o        = val_i[MAN_W-1:0];
        is_zero_o    = (exp_o == '0) && (man_o == '0);
        // all-ones exponent (NaN/inf) or subnormal encoding
        is_special_o = (exp_o == '1) || ((exp_o == '0) && (man_o != '0));
    end
endmodule

// File: rtl/tz_addsub.sv
module tz_addsub #(
    parameter int EXP_W = tz_pkg::EXP_W,
    parameter int MAN_W = tz_pkg::MAN_W,
    parameter int WID_W = tz_pkg::WID_W,
    localparam int FP_W = EXP_W + MAN_W + 1
) (
    input  logic             is_sub_i,
    input  logic [FP_W-1:0]  a_i,
    input  logic [FP_W-1:0]  b_i,
    input  logic [EXP_W-1:0] ea_i,
    input  logic [EXP_W-1:0] eb_i,
    input  logic             za_i,
    input  logic             zb_i,
    input  logic [WID_W-1:0] width_i,
    output logic             hit_o,
    output logic [FP_W-1:0]  res_o
);
    logic             a_big;
    logic [EXP_W-1:0] gap;
    logic [EXP_W:0]   limit;
    logic [FP_W-1:0]  b_signed;

    always_comb begin
        a_big    = (ea_i >= eb_i);
        gap      = a_big ? (ea_i - eb_i) : (eb_i - ea_i);
        limit    = (EXP_W+1)'(width_i) + (EXP_W+1)'(1);
        b_signed = {b_i[FP_W-1] ^ is_sub_i, b_i[FP_W-2:0]};
        hit_o    = 1'b0;
        res_o    = '0;
        if (zb_i) begin
            hit_o = 1'b1;
            res_o = a_i;
        end else if (za_i) begin
            hit_o = 1'b1;
            res_o = b_signed;
        end else if ({1'b0, gap} > limit) begin
            hit_o = 1'b1;
            res_o = a_big ? a_i : b_signed;
        end
    end
endmodule

// File: rtl/tz_muldiv.sv
module tz_muldiv #(
    parameter int EXP_W = tz_pkg::EXP_W,
    parameter int MAN_W = tz_pkg::MAN_W,
    localparam int FP_W = EXP_W + MAN_W + 1,
    localparam int EW   = EXP_W + 2,
    localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
    input  logic             is_div_i,
    input  logic             sa_i,
    input  logic             sb_i,
    input  logic [EXP_W-1:0] ea_i,
    input  logic [EXP_W-1:0] eb_i,
    input  logic [MAN_W-1:0] ma_i,
    input  logic [MAN_W-1:0] mb_i,
    input  logic             za_i,
    input  logic             zb_i,
    input  logic [MAN_W-1:0] keep_mask_i,
    output logic             hit_o,
    output logic [FP_W-1:0]  res_o
);
    logic                 sign;
    logic signed [EW-1:0] exp_sum;
    logic                 exp_ok;
    logic                 pass;
    logic [MAN_W-1:0]     man_sel;

    always_comb begin
        sign    = sa_i ^ sb_i;
        if (is_div_i)
            exp_sum = signed'(EW'(ea_i)) - signed'(EW'(eb_i)) + signed'(EW'(BIAS));
        else
            exp_sum = signed'(EW'(ea_i)) + signed'(EW'(eb_i)) - signed'(EW'(BIAS));
        exp_ok  = (exp_sum >= signed'(EW'(1))) && (exp_sum <= signed'(EW'((1 << EXP_W) - 2)));
        pass    = 1'b0;
        man_sel = '0;
        hit_o   = 1'b0;
        res_o   = '0;
        if (is_div_i) begin
            if (zb_i) begin
                hit_o = 1'b0;
            end else if (za_i) begin
                hit_o = 1'b1;
                res_o = {sign, {(FP_W-1){1'b0}}};
            end else if (mb_i == '0) begin
                pass    = 1'b1;
                man_sel = ma_i;
            end
        end else begin
            if (za_i || zb_i) begin
                hit_o = 1'b1;
                res_o = {sign, {(FP_W-1){1'b0}}};
            end else if ((ma_i & keep_mask_i) == '0) begin
                pass    = 1'b1;
                man_sel = mb_i;
            end else if ((mb_i & keep_mask_i) == '0) begin
                pass    = 1'b1;
                man_sel = ma_i;
            end
        end
        if (pass && exp_ok) begin
            hit_o = 1'b1;
            res_o = {sign, exp_sum[EXP_W-1:0], man_sel};
        end
    end
endmodule

// File: rtl/tz_top.sv
module tz_top
    import tz_pkg::*;
#(
    parameter int P_EXP_W = tz_pkg::EXP_W,
    parameter int P_MAN_W = tz_pkg::MAN_W,
    localparam int P_FP_W = P_EXP_W + P_MAN_W + 1,
    localparam int P_WID_W = $clog2(P_MAN_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_op,
    input  logic [P_FP_W-1:0]  in_a,
    input  logic [P_FP_W-1:0]  in_b,
    input  logic [P_WID_W-1:0] in_width,
    output logic               out_valid,
    output logic               out_hit,
    output logic [P_FP_W-1:0]  out_result
);
    logic [1:0]               sgn;
    logic [1:0][P_EXP_W-1:0]  expo;
    logic [1:0][P_MAN_W-1:0]  man;
    logic [1:0]               zro;
    logic [1:0]               spc;
    logic [1:0][P_FP_W-1:0]   opnd;

    assign opnd[0] = in_a;
    assign opnd[1] = in_b;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        tz_classify #(.EXP_W(P_EXP_W), .MAN_W(P_MAN_W)) u_cls (
            .val_i        (opnd[i]),
            .sign_o       (sgn[i]),
            .exp_o        (expo[i]),
            .man_o        (man[i]),
            .is_zero_o    (zro[i]),
            .is_special_o (spc[i])
        );
    end

    logic [P_WID_W-1:0] width_eff;
    always_comb begin
        if (in_width == '0)
            width_eff = P_WID_W'(1);
        else if (in_width > P_WID_W'(P_MAN_W))
            width_eff = P_WID_W'(P_MAN_W);
        else
            width_eff = in_width;
    end

    // fraction bit k is inside the kept field when k >= MAN_W - w
    logic [P_MAN_W-1:0] keep_mask;
    for (genvar k = 0; k < P_MAN_W; k++) begin : g_mask
        localparam logic [P_WID_W-1:0] NEED = P_WID_W'(P_MAN_W - k);
        assign keep_mask[k] = (width_eff >= NEED);
    end

    tz_op_e op;
    assign op = tz_op_e'(in_op);

    logic              as_hit, md_hit;
    logic [P_FP_W-1:0] as_res, md_res;

    tz_addsub #(.EXP_W(P_EXP_W), .MAN_W(P_MAN_W), .WID_W(P_WID_W)) u_as (
        .is_sub_i (op == OP_SUB),
        .a_i      (in_a),
        .b_i      (in_b),
        .ea_i     (expo[0]),
        .eb_i     (expo[1]),
        .za_i     (zro[0]),
        .zb_i     (zro[1]),
        .width_i  (width_eff),
        .hit_o    (as_hit),
        .res_o    (as_res)
    );

    tz_muldiv #(.EXP_W(P_EXP_W), .MAN_W(P_MAN_W)) u_md (
        .is_div_i    (op == OP_DIV),
        .sa_i        (sgn[0]),
        .sb_i        (sgn[1]),
        .ea_i        (expo[0]),
        .eb_i        (expo[1]),
        .ma_i        (man[0]),
        .mb_i        (man[1]),
        .za_i        (zro[0]),
        .zb_i        (zro[1]),
        .keep_mask_i (keep_mask),
        .hit_o       (md_hit),
        .res_o       (md_res)
    );

    tz_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.valid = 1'b1;
            if (spc == 2'b00) begin
                if (op == OP_ADD || op == OP_SUB) begin
                    st_d.hit = as_hit;
                    st_d.res = as_res;
                end else begin
                    st_d.hit = md_hit;
                    st_d.res = md_res;
                end
            end
            if (!st_d.hit)
                st_d.res = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_hit    = st_q.hit;
    assign out_result = st_q.res;
endmodule

// File: rtl/tz_top_chk.sv
module tz_top_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  in_op,
    input logic [31:0] in_a,
    input logic [31:0] in_b,
    input logic        out_valid,
    input logic        out_hit,
    input logic [31:0] out_result
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_hit && out_result == 32'h0));
    // R11
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> out_result == 32'h0);
    // R9
    special_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_a[30:23] == 8'hFF || in_b[30:23] == 8'hFF)) |=> !out_hit);
    // R3
    add_zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd0 && in_b[30:0] == 31'h0 && in_a[30:23] != 8'hFF
         && (in_a[30:23] != 8'h00 || in_a[22:0] == 23'h0))
        |=> (out_hit && out_result == $past(in_a)));
    // R6 R7
    muldiv_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1]) |=> (!out_hit || out_result[31] == ($past(in_a[31]) ^ $past(in_b[31]))));
endmodule

bind tz_top tz_top_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_hit    (out_hit),
    .out_result (out_result)
);

// File: tb/tb_tz_top.sv
module tb_tz_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic [31:0] in_a = 32'h0;
    logic [31:0] in_b = 32'h0;
    logic [4:0]  in_width = 5'd23;
    logic        out_valid, out_hit;
    logic [31:0] out_result;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tz_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_width(in_width),
        .out_valid(out_valid), .out_hit(out_hit), .out_result(out_result)
    );

    function automatic bit odd(input logic [31:0] x);
        return (x[30:23] == 8'hFF) || (x[30:23] == 8'h00 && x[22:0] != 0);
    endfunction

    // behavioural model: returns {valid, hit, result}
    function automatic logic [33:0] model(input bit v, input int op,
                                          input logic [31:0] a, input logic [31:0] b, input int wraw);
        int w, ea, eb, d, e;
        logic [22:0] ma, mb, mant;
        logic s;
        bit za, zb, ok;
        if (!v) return 34'h0;
        w  = (wraw < 1) ? 1 : ((wraw > 23) ? 23 : wraw);
        ea = a[30:23]; eb = b[30:23]; ma = a[22:0]; mb = b[22:0];
        za = (a[30:0] == 0); zb = (b[30:0] == 0);
        s  = a[31] ^ b[31];
        if (odd(a) || odd(b)) return {2'b10, 32'h0};
        if (op <= 1) begin
            if (zb) return {2'b11, a};
            if (za) return {2'b11, (op == 1) ? (b ^ 32'h8000_0000) : b};
            d = ea - eb;
            if (d > w + 1) return {2'b11, a};
            if (-d > w + 1) return {2'b11, (op == 1) ? (b ^ 32'h8000_0000) : b};
            return {2'b10, 32'h0};
        end
        if (op == 2) begin
            if (za || zb) return {2'b11, s, 31'h0};
            ok = 1;
            if ((ma >> (23 - w)) == 0) mant = mb;
            else if ((mb >> (23 - w)) == 0) mant = ma;
            else ok = 0;
            e = ea + eb - 127;
        end else begin
            if (zb) return {2'b10, 32'h0};
            if (za) return {2'b11, s, 31'h0};
            ok = (mb == 0);
            mant = ma;
            e = ea - eb + 127;
        end
        if (!ok || e < 1 || e > 254) return {2'b10, 32'h0};
        return {2'b11, s, 8'(e), mant};
    endfunction

    // one clock: drive at falling edge, compare one rising edge later
    task automatic step(input bit v, input int op, input logic [31:0] a,
                        input logic [31:0] b, input int w, input string tag);
        logic [33:0] exp_v;
        in_valid = v; in_op = 2'(op); in_a = a; in_b = b; in_width = 5'(w);
        exp_v = model(v, op, a, b, w);
        @(negedge clk);
        total++;
        if ({out_valid, out_hit, out_result} !== exp_v) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h w=%0d actual=%b/%b/%h expected=%b/%b/%h",
                     tag, op, a, b, w, out_valid, out_hit, out_result,
                     exp_v[33], exp_v[32], exp_v[31:0]);
        end
    endtask

    task automatic expect_hit(input bit h, input logic [31:0] r, input string tag);
        total++;
        if (out_hit !== h || out_result !== r) begin
            bad++;
            $display("FAIL %s actual=%b/%h expected=%b/%h", tag, out_hit, out_result, h, r);
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        bad++; total++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        logic [31:0] pool [8];
        pool = '{32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000, 32'h3FA0_0000,
                 32'h4981_2345, 32'h0000_0000, 32'h7F00_0000, 32'hC060_0000};
        repeat (3) @(negedge clk);
        // R1 reset state
        total++;
        if (out_valid !== 0 || out_hit !== 0 || out_result !== 0) begin
            bad++;
            $display("FAIL R1 actual=%b/%b/%h expected=0/0/0", out_valid, out_hit, out_result);
        end
        rst_n = 1'b1;
        step(0, 0, 32'h3FC0_0000, 0, 23, "R2");
        // R3 zero operands
        step(1, 0, 32'h3FC0_0000, 32'h0000_0000, 10, "R3");
        expect_hit(1, 32'h3FC0_0000, "R3");
        step(1, 1, 32'h0000_0000, 32'h3FC0_0000, 10, "R3");
        expect_hit(1, 32'hBFC0_0000, "R3");
        step(1, 0, 32'h8000_0000, 32'h4040_0000, 5, "R3");
        // R4 gap 20: w=10 hit, w=19 miss (equal to w+1), w=18 hit
        step(1, 0, 32'h4981_2345, 32'h3FC0_0000, 10, "R4");
        expect_hit(1, 32'h4981_2345, "R4");
        step(1, 0, 32'h4981_2345, 32'h3FC0_0000, 19, "R4");
        expect_hit(0, 32'h0, "R4");
        step(1, 0, 32'h4981_2345, 32'h3FC0_0000, 18, "R4");
        step(1, 1, 32'h3FC0_0000, 32'h4981_2345, 10, "R4");
        expect_hit(1, 32'hC981_2345, "R4");
        // R10 clamp above 23: gap 25 hits, gap 24 misses
        step(1, 0, 32'h4C00_0000, 32'h3F80_0000, 30, "R10");
        expect_hit(1, 32'h4C00_0000, "R10");
        step(1, 0, 32'h4B80_0000, 32'h3F80_0000, 31, "R10");
        expect_hit(0, 32'h0, "R10");
        // R5 signed zero products
        step(1, 2, 32'h0000_0000, 32'hC040_0000, 7, "R5");
        expect_hit(1, 32'h8000_0000, "R5");
        // R6 power-of-two factor
        step(1, 2, 32'h3FA0_0000, 32'h4040_0000, 1, "R6");
        expect_hit(1, 32'h4040_0000, "R6");
        step(1, 2, 32'h3FA0_0000, 32'h4040_0000, 2, "R6");
        expect_hit(0, 32'h0, "R6");
        step(1, 2, 32'h3FA0_0000, 32'h4040_0000, 0, "R10");
        expect_hit(1, 32'h4040_0000, "R10");
        step(1, 2, 32'hC000_0000, 32'h3FE0_0000, 23, "R6");
        expect_hit(1, 32'hC060_0000, "R6");
        // R7 divide
        step(1, 3, 32'h4040_0000, 32'h4000_0000, 4, "R7");
        expect_hit(1, 32'h3FC0_0000, "R7");
        step(1, 3, 32'h3FC0_0000, 32'h3FA0_0000, 1, "R7");
        expect_hit(0, 32'h0, "R7");
        step(1, 3, 32'h0000_0000, 32'hC040_0000, 9, "R7");
        expect_hit(1, 32'h8000_0000, "R7");
        step(1, 3, 32'h4040_0000, 32'h0000_0000, 9, "R7");
        expect_hit(0, 32'h0, "R7");
        // R8 exponent out of range
        step(1, 2, 32'h7F00_0000, 32'h4000_0000, 23, "R8");
        expect_hit(0, 32'h0, "R8");
        step(1, 3, 32'h0080_0000, 32'h4000_0000, 23, "R8");
        expect_hit(0, 32'h0, "R8");
        // R9 NaN, infinity, subnormal
        step(1, 0, 32'h7FC0_0000, 32'h0000_0000, 23, "R9");
        expect_hit(0, 32'h0, "R9");
        step(1, 2, 32'hFF80_0000, 32'h3F80_0000, 23, "R9");
        step(1, 0, 32'h0000_0001, 32'h0000_0000, 23, "R9");
        expect_hit(0, 32'h0, "R9");
        step(0, 2, 32'h3F80_0000, 32'h3F80_0000, 23, "R11");
        // mixed stream
        lcg = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a, b;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = lcg[3] ? pool[lcg[6:4]] : {lcg[31], lcg[30:23] ^ 8'h40, lcg[22:0] & {lcg[9:7], 20'h0}};
            b = lcg[10] ? pool[lcg[13:11]] : {lcg[14], lcg[22:15], lcg[29:23], 16'h0};
            step(lcg[2:0] != 0, int'(lcg[17:16]), a, b, int'(lcg[28:24]), "R11");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule